// File: doc/BRIEF.md
# ATAPI Command Packet Decoder with Sense Reporting

This block sits behind the task-file sequencer of a packet-interface drive. It takes a complete 12-byte command packet in one strobe, decodes the opcode and its fields, and chooses one of three outcomes. The first is a data-in transfer whose length is clamped, served from a built-in identification table or from a snapshot of the sense buffer. The second is a sector read sequence run against a media model. The third is an immediate completion with no data phase.

Every outcome is reported through one result path. That path turns a 16-bit result code into sense bytes, an error register and a status value, and it raises an interrupt pulse when needed. After reset the block holds a unit-attention condition. The first command that is not a sense request is refused with a reset result, and that refusal clears the condition.

The sequencer reads data-in bytes through an index/byte port. It marks the end of each media sector with a done strobe. The media model receives one request per sector and answers each with a status code and a length.

Top module: `atapi_pkt_decoder`

## Requirements
- R1: After reset, status, error and count read 0x00, and every sense byte is zero. The unit-attention flag is set and `pkt_ready` is high.
- R2: A reported result code C sets the following: sense byte 0 = 0xF0, sense byte 2 = C[7:0], sense byte 8 = C[15:8], error = C[3:0] shifted left by 4, and count = 3. `res_valid` pulses with `res_code` = C one cycle after the cause.
- R3: A nonzero result sets status to 0x51 and pulses `irq`. A zero result clears only status bits 7 and 0, unless R8 or R12 sets a status of its own.
- R4: While the unit-attention flag is set, any packet whose opcode (byte 0) is not request-sense (0x13) reports result 0x2906, clears the flag and has no other effect. Request-sense leaves the flag as it is.
- R5: Request-sense reports result 0 and starts a data-in of min(byte 4, 10) bytes. Those bytes are the sense buffer as it stood before this command's own result.
- R6: Identify (0x11) reads byte 2 as an offset into a 32-byte table whose entry k is (8k+5) XOR 0x5A. The length is min(byte 4, 32 - offset). An offset of 32 or more reports result 0x2405 with no data phase.
- R7: Test-ready (0x00), play (0x20), spin-up (0x70) and sector read (0x30) report 0x3A02 when `media_present` is low. Any opcode that is not decoded reports 0x2005.
- R8: With media present, test-ready, play and spin-up report result 0, set status 0x50 and pulse `irq`, and start no data phase.
- R9: A sector read takes its start block from bytes 2..4 and its block count from bytes 8..10, both most significant byte first, and its mode from byte 1. It then requests the sectors at consecutive block addresses with that mode. `pkt_ready` is low until the sequence ends.
- R10: Each good sector increments the block address and decrements the remaining count. The next request waits for `xfer_done`, and no request follows the last block. A count of zero reports result 0 with status 0x50 and requests nothing.
- R11: A failed sector reports its status code, writes the failing block address into sense bytes 5, 6 and 7 (high byte first) and ends the sequence.
- R12: Every data-in start pulses `rd_start` and `irq`, sets count to 2 and status to 0x58, and gives the length on `rd_len`. `rd_from_media` is high only for sector data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet strobe, taken when `pkt_ready` is high |
| pkt_bytes | input | 96 | Packet, byte i at bits [8i+7:8i] |
| pkt_ready | output | 1 | No sector sequence running |
| media_present | input | 1 | Media is loaded |
| status_o | output | 8 | Status register |
| error_o | output | 8 | Error register |
| count_o | output | 8 | Interrupt-reason/count register |
| irq_o | output | 1 | Interrupt raise pulse |
| res_valid | output | 1 | Result reported this cycle |
| res_code | output | 16 | Reported result code |
| rd_start | output | 1 | Data-in transfer start pulse |
| rd_len | output | LEN_W | Data-in length in bytes |
| rd_from_media | output | 1 | Data-in comes from media |
| xfer_idx | input | 5 | Data-in byte index |
| xfer_byte | output | 8 | Data-in byte at `xfer_idx` |
| xfer_done | input | 1 | Current sector fully moved |
| sec_req_valid | output | 1 | Sector request |
| sec_req_ready | input | 1 | Media accepts the request |
| sec_req_lba | output | 24 | Requested block address |
| sec_req_mode | output | 8 | Read mode |
| sec_ack_valid | input | 1 | Media answer strobe |
| sec_ack_status | input | 16 | Media status, 0 for success |
| sec_ack_len | input | LEN_W | Sector length in bytes |

## Verification
The decoder runs against packets that separate its outcomes. The same opcode is sent first while unit attention is pending and then after it is cleared, which shows the gate from normal decoding. Request-sense is sent both inside and outside the gate and is read back byte by byte, which shows which result reached the sense buffer. Identify is sent with an offset inside the table, one near its end and one past it, which exercise the plain length, the clamped length and the field error. Sector reads are sent with a multi-block count, a zero count, missing media and a mid-sequence media failure, which separate address stepping, immediate completion, refusal and the capture of the failing address.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam int PKT_BYTES   = 12;
  localparam int SENSE_BYTES = 10;
  localparam int ID_BYTES    = 32;
  localparam int IDX_W       = $clog2(ID_BYTES);

  localparam logic [7:0] ST_ERR   = 8'h51;
  localparam logic [7:0] ST_READY = 8'h50;
  localparam logic [7:0] ST_DATA  = 8'h58;
  localparam logic [7:0] ST_BSY   = 8'h80;
  localparam logic [7:0] ST_CHK   = 8'h01;
  localparam logic [7:0] CNT_IO   = 8'h02;
  localparam logic [7:0] CNT_DONE = 8'h03;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_ACK, SQ_XFER} seq_state_t;

  // identification table entry k
  function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] k);
    return {k, 3'b101} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] clamp_len(input logic [7:0] want, input logic [7:0] lim);
    return (want > lim) ? lim : want;
  endfunction

  function automatic logic [7:0] err_field(input logic [15:0] code);
    return {code[3:0], 4'h0};
  endfunction
endpackage

// File: rtl/pkt_result.sv
module pkt_result import pkt_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rep_v,
  input  logic [15:0] rep_code,
  input  logic        lba_v,
  input  logic [23:0] lba,
  input  logic        rd_v,
  input  logic        done_v,
  input  logic        busy_v,
  output logic [SENSE_BYTES*8-1:0] sense_flat,
  output logic [7:0]  status,
  output logic [7:0]  error,
  output logic [7:0]  count,
  output logic        irq,
  output logic        res_v,
  output logic [15:0] res_code
);
  logic [7:0] sense_q [SENSE_BYTES];
  logic [7:0] status_d;
  logic       rep_bad;

  assign rep_bad = rep_v && (rep_code != 16'h0);

  always_comb begin
    status_d = status;
    if (rep_bad)      status_d = ST_ERR;
    else if (rd_v)    status_d = ST_DATA;
    else if (done_v)  status_d = ST_READY;
    else if (rep_v)   status_d = status & ~(ST_BSY | ST_CHK);
    else if (busy_v)  status_d = status | ST_BSY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SENSE_BYTES; i++) sense_q[i] <= '0;
      status   <= '0;
      error    <= '0;
      count    <= '0;
      irq      <= 1'b0;
      res_v    <= 1'b0;
      res_code <= '0;
    end else begin
      if (rep_v) begin
        sense_q[0] <= 8'hF0;
        sense_q[2] <= rep_code[7:0];
        sense_q[8] <= rep_code[15:8];
        error      <= err_field(rep_code);
      end
      if (lba_v) begin
        sense_q[5] <= lba[23:16];
        sense_q[6] <= lba[15:8];
        sense_q[7] <= lba[7:0];
      end
      if (rd_v)       count <= CNT_IO;
      else if (rep_v) count <= CNT_DONE;
      status   <= status_d;
      irq      <= rep_bad || rd_v || done_v;
      res_v    <= rep_v;
      res_code <= rep_code;
    end
  end

  for (genvar g = 0; g < SENSE_BYTES; g++) begin : g_flat
    assign sense_flat[8*g +: 8] = sense_q[g];
  end

  // R2: a reported code lands in the sense bytes
  p_sense_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_v |-> (sense_flat[7:0] == 8'hF0) && (sense_flat[23:16] == res_code[7:0])
              && (sense_flat[71:64] == res_code[15:8]));
  // R3: nonzero result gives error status and an interrupt
  p_err_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_v && res_code != 16'h0) |-> (status == ST_ERR) && irq);
  // R12: data-in start shows the data status
  p_read_status_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_v |=> (count == CNT_IO) && irq);
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq import pkt_pkg::*; #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      st_lba,
  input  logic [23:0]      st_cnt,
  input  logic [7:0]       st_mode,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [23:0]      req_lba,
  output logic [7:0]       req_mode,
  input  logic             ack_valid,
  input  logic [15:0]      ack_status,
  input  logic [LEN_W-1:0] ack_len,
  input  logic             xfer_done,
  output logic             ev_read,
  output logic [LEN_W-1:0] ev_len,
  output logic             ev_fail,
  output logic [15:0]      ev_code,
  output logic [23:0]      ev_lba,
  output logic             busy
);
  seq_state_t st;
  logic [23:0] lba_q, left_q;
  logic [7:0]  mode_q;
  logic        ack_take;

  assign req_valid = (st == SQ_REQ);
  assign req_lba   = lba_q;
  assign req_mode  = mode_q;
  assign ack_take  = (st == SQ_ACK) && ack_valid;
  assign ev_read   = ack_take && (ack_status == 16'h0);
  assign ev_fail   = ack_take && (ack_status != 16'h0);
  assign ev_len    = ack_len;
  assign ev_code   = ack_status;
  assign ev_lba    = lba_q;
  assign busy      = (st != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      lba_q  <= '0;
      left_q <= '0;
      mode_q <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (start && st_cnt != 24'h0) begin
          lba_q  <= st_lba;
          left_q <= st_cnt;
          mode_q <= st_mode;
          st     <= SQ_REQ;
        end
        SQ_REQ: if (req_ready) st <= SQ_ACK;
        SQ_ACK: if (ack_valid) begin
          if (ack_status == 16'h0) begin
            lba_q  <= lba_q + 24'd1;
            left_q <= left_q - 24'd1;
            st     <= SQ_XFER;
          end else begin
            st <= SQ_IDLE;
          end
        end
        SQ_XFER: if (xfer_done) st <= (left_q == 24'h0) ? SQ_IDLE : SQ_REQ;
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R10: a good sector steps the address and the count
  p_lba_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read |=> (lba_q == $past(lba_q) + 24'd1) && (left_q == $past(left_q) - 24'd1));
  // R9: a pending request holds its address
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_lba));
  // R11: a failure ends the sequence
  p_fail_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |=> !busy);
endmodule

// File: rtl/atapi_pkt_decoder.sv
module atapi_pkt_decoder import pkt_pkg::*; #(
  parameter int          LEN_W        = 12,
  parameter logic [7:0]  OP_TEST      = 8'h00,
  parameter logic [7:0]  OP_SENSE     = 8'h13,
  parameter logic [7:0]  OP_IDENT     = 8'h11,
  parameter logic [7:0]  OP_PLAY      = 8'h20,
  parameter logic [7:0]  OP_READ      = 8'h30,
  parameter logic [7:0]  OP_SPIN      = 8'h70,
  parameter logic [15:0] RES_RESET    = 16'h2906,
  parameter logic [15:0] RES_NODISC   = 16'h3A02,
  parameter logic [15:0] RES_BADCMD   = 16'h2005,
  parameter logic [15:0] RES_BADFIELD = 16'h2405
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pkt_valid,
  input  logic [PKT_BYTES*8-1:0] pkt_bytes,
  output logic                 pkt_ready,
  input  logic                 media_present,
  output logic [7:0]           status_o,
  output logic [7:0]           error_o,
  output logic [7:0]           count_o,
  output logic                 irq_o,
  output logic                 res_valid,
  output logic [15:0]          res_code,
  output logic                 rd_start,
  output logic [LEN_W-1:0]     rd_len,
  output logic                 rd_from_media,
  input  logic [IDX_W-1:0]     xfer_idx,
  output logic [7:0]           xfer_byte,
  input  logic                 xfer_done,
  output logic                 sec_req_valid,
  input  logic                 sec_req_ready,
  output logic [23:0]          sec_req_lba,
  output logic [7:0]           sec_req_mode,
  input  logic                 sec_ack_valid,
  input  logic [15:0]          sec_ack_status,
  input  logic [LEN_W-1:0]     sec_ack_len
);
  logic [7:0] b [PKT_BYTES];
  for (genvar g = 0; g < PKT_BYTES; g++) begin : g_unpack
    assign b[g] = pkt_bytes[8*g +: 8];
  end

  logic unused_bytes;
  assign unused_bytes = ^{b[5], b[6], b[7], b[11]};

  logic             seq_busy, ev_read, ev_fail;
  logic [LEN_W-1:0] ev_len;
  logic [15:0]      ev_code;
  logic [23:0]      ev_lba, blk_lba, blk_cnt;
  logic             accept, attn_q, gate, needs_media;
  logic             rep_v, done_v, rd_v, seq_go, clr_attn, snap_en, id_en;
  logic [15:0]      rep_code_d;
  logic [LEN_W-1:0] rd_len_d;
  logic [SENSE_BYTES*8-1:0] sense_flat;
  logic [7:0]       snap_q [SENSE_BYTES];
  logic [IDX_W-1:0] off_q;
  logic             src_sense_q;

  assign pkt_ready   = !seq_busy;
  assign accept      = pkt_valid && pkt_ready;
  assign gate        = attn_q && (b[0] != OP_SENSE);
  assign needs_media = (b[0] == OP_TEST) || (b[0] == OP_PLAY) ||
                       (b[0] == OP_SPIN) || (b[0] == OP_READ);
  assign blk_lba     = {b[2], b[3], b[4]};
  assign blk_cnt     = {b[8], b[9], b[10]};

  always_comb begin
    rep_v = 1'b0; rep_code_d = '0; done_v = 1'b0; rd_v = 1'b0; rd_len_d = '0;
    seq_go = 1'b0; clr_attn = 1'b0; snap_en = 1'b0; id_en = 1'b0;
    if (accept) begin
      if (gate) begin
        rep_v = 1'b1; rep_code_d = RES_RESET; clr_attn = 1'b1;
      end else if (b[0] == OP_SENSE) begin
        rep_v = 1'b1; rd_v = 1'b1; snap_en = 1'b1;
        rd_len_d = LEN_W'(clamp_len(b[4], 8'(SENSE_BYTES)));
      end else if (b[0] == OP_IDENT) begin
        rep_v = 1'b1;
        if (b[2] >= 8'(ID_BYTES)) rep_code_d = RES_BADFIELD;
        else begin
          rd_v = 1'b1; id_en = 1'b1;
          rd_len_d = LEN_W'(clamp_len(b[4], 8'(ID_BYTES) - b[2]));
        end
      end else if (needs_media && !media_present) begin
        rep_v = 1'b1; rep_code_d = RES_NODISC;
      end else if (b[0] == OP_READ) begin
        if (blk_cnt == 24'h0) begin rep_v = 1'b1; done_v = 1'b1; end
        else seq_go = 1'b1;
      end else if (needs_media) begin
        rep_v = 1'b1; done_v = 1'b1;
      end else begin
        rep_v = 1'b1; rep_code_d = RES_BADCMD;
      end
    end
  end

  pkt_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_go), .st_lba(blk_lba), .st_cnt(blk_cnt),
    .st_mode(b[1]), .req_valid(sec_req_valid), .req_ready(sec_req_ready),
    .req_lba(sec_req_lba), .req_mode(sec_req_mode), .ack_valid(sec_ack_valid),
    .ack_status(sec_ack_status), .ack_len(sec_ack_len), .xfer_done(xfer_done),
    .ev_read(ev_read), .ev_len(ev_len), .ev_fail(ev_fail), .ev_code(ev_code),
    .ev_lba(ev_lba), .busy(seq_busy)
  );

  pkt_result u_res (
    .clk(clk), .rst_n(rst_n), .rep_v(rep_v || ev_fail),
    .rep_code(ev_fail ? ev_code : rep_code_d), .lba_v(ev_fail), .lba(ev_lba),
    .rd_v(rd_v || ev_read), .done_v(done_v), .busy_v(seq_go),
    .sense_flat(sense_flat), .status(status_o), .error(error_o), .count(count_o),
    .irq(irq_o), .res_v(res_valid), .res_code(res_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attn_q        <= 1'b1;
      rd_start      <= 1'b0;
      rd_len        <= '0;
      rd_from_media <= 1'b0;
      off_q         <= '0;
      src_sense_q   <= 1'b0;
      for (int i = 0; i < SENSE_BYTES; i++) snap_q[i] <= '0;
    end else begin
      if (clr_attn) attn_q <= 1'b0;
      rd_start <= rd_v || ev_read;
      if (rd_v) begin
        rd_len <= rd_len_d; rd_from_media <= 1'b0;
      end else if (ev_read) begin
        rd_len <= ev_len;   rd_from_media <= 1'b1;
      end
      if (id_en) begin
        off_q <= b[2][IDX_W-1:0]; src_sense_q <= 1'b0;
      end
      if (snap_en) begin
        src_sense_q <= 1'b1;
        for (int i = 0; i < SENSE_BYTES; i++) snap_q[i] <= sense_flat[8*i +: 8];
      end
    end
  end

  always_comb begin
    xfer_byte = '0;
    if (src_sense_q) begin
      for (int i = 0; i < SENSE_BYTES; i++)
        if (xfer_idx == IDX_W'(i)) xfer_byte = snap_q[i];
    end else begin
      xfer_byte = id_byte(off_q + xfer_idx);
    end
  end

  // R4: a gated packet reports the reset code and nothing else
  p_unit_att_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && gate) |=> res_valid && (res_code == RES_RESET) && !rd_start);
  // R6: table transfers never exceed the table
  p_len_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !rd_from_media) |-> (rd_len <= LEN_W'(ID_BYTES)));
  // R8: immediate completion has no data phase
  p_quiet_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !gate && media_present && (b[0] == OP_TEST || b[0] == OP_SPIN)) |=>
      res_valid && !rd_start && (status_o == ST_READY));
  // R9: the sequencer only requests media while the port is closed
  p_busy_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_req_valid |-> !pkt_ready);
endmodule

// File: tb/atapi_pkt_decoder_tb.sv
`timescale 1ns/1ps
module atapi_pkt_decoder_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, pkt_valid, pkt_ready, media_present, irq_o, res_valid, rd_start, rd_from_media;
  logic [95:0] pkt_bytes;
  logic [7:0]  status_o, error_o, count_o, xfer_byte, sec_req_mode;
  logic [15:0] res_code, sec_ack_status;
  logic [11:0] rd_len, sec_ack_len;
  logic [4:0]  xfer_idx;
  logic xfer_done, sec_req_valid, sec_req_ready, sec_ack_valid;
  logic [23:0] sec_req_lba;

  atapi_pkt_decoder u_dut (.*);

  typedef struct { string tag; logic [54:0] v; } item_t;
  item_t expq[$];
  int n_cmp = 0, n_bad = 0;
  logic [7:0]  m_err;
  logic [23:0] exp_lba, fail_lba;
  logic [7:0]  exp_mode;
  localparam logic [11:0] SEC_LEN = 12'd2048;
  localparam logic [15:0] C_RESET = 16'h2906, C_NODISC = 16'h3A02, C_BADCMD = 16'h2005,
                          C_BADFIELD = 16'h2405, C_FAIL = 16'h1103;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected event: result fields, data-in fields, registers, irq
  task automatic push(input string tag, input logic rv, input logic [15:0] code,
                      input logic rdv, input logic [11:0] len, input logic [7:0] st,
                      input logic [7:0] cnt);
    item_t it;
    if (rv) m_err = {code[3:0], 4'h0};
    it.tag = tag;
    it.v = {rv, rv ? code : 16'h0, rdv, rdv ? len : 12'h0, st, m_err, cnt, 1'b1};
    expq.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && (res_valid || rd_start)) begin
      logic [54:0] act;
      act = {res_valid, res_valid ? res_code : 16'h0, rd_start, rd_start ? rd_len : 12'h0,
             status_o, error_o, count_o, irq_o};
      if (expq.size() == 0) chk("unexpected event R2", {9'h0, act}, 64'h0);
      else begin
        item_t it;
        it = expq.pop_front();
        chk(it.tag, {9'h0, act}, {9'h0, it.v});
      end
    end
  end

  // media model
  initial begin
    sec_req_ready = 0; sec_ack_valid = 0; sec_ack_status = 0; sec_ack_len = 0; xfer_done = 0;
    forever begin
      @(negedge clk);
      if (sec_req_valid) begin
        logic [23:0] l;
        l = sec_req_lba;
        chk("R9 request lba", {40'h0, l}, {40'h0, exp_lba});
        chk("R9 request mode", {56'h0, sec_req_mode}, {56'h0, exp_mode});
        exp_lba = exp_lba + 1;
        sec_req_ready = 1;
        @(negedge clk); sec_req_ready = 0;
        @(negedge clk);
        sec_ack_valid = 1; sec_ack_len = SEC_LEN;
        sec_ack_status = (l == fail_lba) ? C_FAIL : 16'h0;
        @(negedge clk); sec_ack_valid = 0;
        if (l != fail_lba) begin
          repeat (3) @(negedge clk);
          chk("R10 no early request", {63'h0, sec_req_valid}, 64'h0);
          xfer_done = 1; @(negedge clk); xfer_done = 0;
        end
      end
    end
  end

  function automatic logic [95:0] mk(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                                     input logic [7:0] b3, input logic [7:0] b4, input logic [23:0] cnt);
    logic [95:0] p = '0;
    p[7:0] = op; p[15:8] = b1; p[23:16] = b2; p[31:24] = b3; p[39:32] = b4;
    p[71:64] = cnt[23:16]; p[79:72] = cnt[15:8]; p[87:80] = cnt[7:0];
    return p;
  endfunction

  task automatic send(input logic [95:0] p);
    @(negedge clk);
    while (!pkt_ready) @(negedge clk);
    pkt_bytes = p; pkt_valid = 1;
    @(negedge clk); pkt_valid = 0;
    repeat (2) @(negedge clk);
    while (!pkt_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_bytes(input string tag, input int n, input logic [7:0] exp [10]);
    for (int i = 0; i < n; i++) begin
      xfer_idx = 5'(i); #1;
      chk(tag, {56'h0, xfer_byte}, {56'h0, exp[i]});
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] sb [10];
    rst_n = 0; pkt_valid = 0; pkt_bytes = '0; media_present = 1; xfer_idx = 0;
    m_err = 0; exp_lba = 0; exp_mode = 0; fail_lba = 24'hFFFFFF;
    repeat (4) @(negedge clk); rst_n = 1; @(negedge clk);
    // R1 reset state
    chk("R1 status", {56'h0, status_o}, 64'h0);
    chk("R1 error", {56'h0, error_o}, 64'h0);
    chk("R1 count", {56'h0, count_o}, 64'h0);
    chk("R1 ready", {63'h0, pkt_ready}, 64'h1);
    // R5 sense allowed under unit attention, clamped to 10, all-zero buffer (R1)
    push("R5 sense under attention", 1, 0, 1, 12'd10, 8'h58, 8'h02);
    send(mk(8'h13, 0, 0, 0, 8'd20, 0));
    for (int i = 0; i < 10; i++) sb[i] = 8'h00;
    read_bytes("R1 sense zero", 10, sb);
    // R4 first other command refused
    push("R4 reset gate", 1, C_RESET, 0, 0, 8'h51, 8'h03);
    send(mk(8'h00, 0, 0, 0, 0, 0));
    // R2 sense reflects the reset code
    push("R5 sense after gate", 1, 0, 1, 12'd4, 8'h58, 8'h02);
    send(mk(8'h13, 0, 0, 0, 8'd4, 0));
    sb[0] = 8'hF0; sb[2] = C_RESET[7:0]; sb[8] = C_RESET[15:8];
    read_bytes("R2 sense layout", 4, sb);
    // R8 immediate completions
    push("R8 test-ready", 1, 0, 0, 0, 8'h50, 8'h03);
    send(mk(8'h00, 0, 0, 0, 0, 0));
    push("R8 play", 1, 0, 0, 0, 8'h50, 8'h03);
    send(mk(8'h20, 0, 0, 0, 0, 0));
    push("R8 spin-up", 1, 0, 0, 0, 8'h50, 8'h03);
    send(mk(8'h70, 0, 0, 0, 0, 0));
    // R7 unknown opcode, no media
    push("R7 bad opcode", 1, C_BADCMD, 0, 0, 8'h51, 8'h03);
    send(mk(8'h5F, 0, 0, 0, 0, 0));
    media_present = 0;
    push("R7 no disc test", 1, C_NODISC, 0, 0, 8'h51, 8'h03);
    send(mk(8'h00, 0, 0, 0, 0, 0));
    push("R7 no disc read", 1, C_NODISC, 0, 0, 8'h51, 8'h03);
    send(mk(8'h30, 0, 0, 0, 8'h10, 24'd2));
    // R6 identify (no media needed)
    push("R6 identify", 1, 0, 1, 12'd8, 8'h58, 8'h02);
    send(mk(8'h11, 0, 8'd4, 0, 8'd8, 0));
    for (int i = 0; i < 8; i++) sb[i] = 8'((8 * (4 + i) + 5) ^ 8'h5A);
    read_bytes("R6 table data", 8, sb);
    push("R6 identify clamped", 1, 0, 1, 12'd2, 8'h58, 8'h02);
    send(mk(8'h11, 0, 8'd30, 0, 8'd8, 0));
    sb[0] = 8'((8 * 30 + 5) ^ 8'h5A); sb[1] = 8'((8 * 31 + 5) ^ 8'h5A);
    read_bytes("R6 clamped data", 2, sb);
    push("R6 bad offset", 1, C_BADFIELD, 0, 0, 8'h51, 8'h03);
    send(mk(8'h11, 0, 8'd32, 0, 8'd4, 0));
    media_present = 1;
    // R10 zero count
    push("R10 zero count", 1, 0, 0, 0, 8'h50, 8'h03);
    send(mk(8'h30, 8'h2A, 8'h01, 8'h23, 8'h45, 24'd0));
    // R9 R10 R12 three sectors
    exp_lba = 24'h012345; exp_mode = 8'h2A;
    for (int i = 0; i < 3; i++) push("R12 sector start", 0, 0, 1, SEC_LEN, 8'h58, 8'h02);
    send(mk(8'h30, 8'h2A, 8'h01, 8'h23, 8'h45, 24'd3));
    chk("R10 request count", {40'h0, exp_lba}, {40'h0, 24'h012348});
    chk("R12 media source", {63'h0, rd_from_media}, 64'h1);
    // R11 failing second sector
    exp_lba = 24'h000100; exp_mode = 8'h20; fail_lba = 24'h000101;
    push("R12 sector before fail", 0, 0, 1, SEC_LEN, 8'h58, 8'h02);
    push("R11 sector fail", 1, C_FAIL, 0, 0, 8'h51, 8'h03);
    send(mk(8'h30, 8'h20, 8'h00, 8'h01, 8'h00, 24'd3));
    chk("R11 sequence ended", {40'h0, exp_lba}, {40'h0, 24'h000102});
    push("R5 sense after fail", 1, 0, 1, 12'd10, 8'h58, 8'h02);
    send(mk(8'h13, 0, 0, 0, 8'd10, 0));
    sb = '{8'hF0, 8'h00, C_FAIL[7:0], 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, C_FAIL[15:8], 8'h00};
    read_bytes("R11 sense lba", 10, sb);
    repeat (5) @(negedge clk);
    chk("R2 queue drained", 64'(expq.size()), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule